// File: doc/BRIEF.md
# Transition Position Frame Encoder

This block watches a slow data line and summarises each 125 µs window as one 8-bit code word. It runs from the 2.048 MHz bit clock of a serial TDM channel and cuts every window into 32 timeslots of eight clock cycles each. It records when the line changed, how often it changed and how far apart the changes were. The result is one word per window that a serializer can send in a single 64 kbps channel. This way the data is not sampled over and over at a high rate.

Two line forms are accepted. In single-line NRZ form, `line_a` carries the level and `line_b` is not used. In two-line RZ form, each line carries active-low pulses. One line marks the start of a MARK run and the other marks the start of a SPACE run, and `mark_sel` picks which line is which. A pulse that arrives on the line of the level already held is a violation pulse. It is coded like a single transition, but only the first one in a window counts. The finished word is latched at the window boundary and flagged by a one-cycle `word_valid` strobe. It then holds for a whole window, so the serializer always reads a stable word for the window just closed.

Top module: `tpe_encoder`

## Requirements
- R1: While reset is asserted, and until the first strobe, `code_word` is 8'h7F and `word_valid` is 0. The held level starts at 0 (SPACE).
- R2: `word_valid` pulses for one cycle every 256 cycles. The first pulse comes after the first complete window following reset.
- R3: A window with no counted event codes bits 6..0 as 7'b11_11111.
- R4: A window with exactly one counted event codes bits 6..5 = 2'b10 and bits 4..0 = the timeslot of that event (0 to 31).
- R5: Two events whose slot gap is at most 19 code 2'b11 in bits 6..5 and the first slot in bits 4..0, provided the first slot is at most 17.
- R6: Two events more than 19 slots apart with the first slot at 4 or later code 2'b01 in bits 6..5 and the first slot in bits 4..0.
- R7: Two events more than 19 slots apart with the first slot in 0..3 code 2'b00 in bits 6..5. Bits 1..0 hold the first slot and bits 4..2 hold the second slot minus 28, with 0 used when the second slot is below 28.
- R8: Three or more events with the first two gaps each at most 19 and the first slot at most 4 code 2'b11 in bits 6..5 and the first slot in bits 4..0.
- R9: Any other pattern of two or more events codes 2'b10 in bits 6..5 and the first slot in bits 4..0.
- R10: Bit 7 is the data level held at the end of timeslot 31 of the window (1 = MARK).
- R11: In RZ mode (`rz_mode`=1), a falling edge on the MARK line sets the level to 1 and a falling edge on the SPACE line sets it to 0. `line_a` is the MARK line when `mark_sel`=0 and `line_b` is the MARK line when `mark_sel`=1. A pulse on the line of the level already held is a violation: it counts as an event and leaves the level unchanged. In NRZ mode each change of `line_a` is an event.
- R12: Only the first violation pulse in a window is counted. Later violations in the same window are ignored.
- R13: In RZ mode, a falling edge on one line is ignored while the other line is also low.
- R14: `code_word` changes only in the cycle in which `word_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rz_mode | input | 1 | 1 = two-line RZ pulses, 0 = single-line NRZ |
| mark_sel | input | 1 | RZ only: 0 = `line_a` is the MARK line, 1 = `line_b` is |
| line_a | input | 1 | NRZ data, or RZ pulse line A (active low) |
| line_b | input | 1 | RZ pulse line B (active low) |
| code_word | output | 8 | Code word for the most recently completed window |
| word_valid | output | 1 | One-cycle strobe marking a new `code_word` |

## Verification
A line change made while the window counter reads c passes through two synchronizer flops. It therefore becomes an event in the cycle where the counter reads c+2. The bench changes lines at counter value 8·slot+1, so each event is stamped in its intended slot with margin on both sides. The word for a window appears one cycle after that window's last cycle, together with `word_valid`. The bench samples it at the falling edge where the strobe is high and checks that the strobe is low and the word unchanged at the next falling edge. Each window's expected word comes from a bench-side model of the level, event and violation rules, fed with the slots the bench itself scheduled.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
  localparam int SLOTS     = 32;
  localparam int SLOT_W    = 5;
  localparam int SHORT_GAP = 19;  // largest slot gap still counted as short spacing
  localparam int LATE_BASE = 28;  // base slot of the second-event field in the 00 type

  typedef logic [SLOT_W-1:0] slot_t;

  // Offset of the second event from the late base slot, clamped at zero.
  function automatic logic [2:0] late_offset(input slot_t s);
    if (int'(s) >= LATE_BASE) return 3'(int'(s) - LATE_BASE);
    return 3'd0;
  endfunction

  // Pack level, event count (saturated at 3) and first three slots into a word.
  function automatic logic [7:0] tpe_pack(input logic lvl, input logic [1:0] n,
                                          input slot_t s0, input slot_t s1, input slot_t s2);
    logic [6:0] low;
    int g1, g2;
    g1 = int'(s1) - int'(s0);
    g2 = int'(s2) - int'(s1);
    case (n)
      2'd0: low = 7'h7F;
      2'd1: low = {2'b10, s0};
      2'd2: begin
        if (g1 <= SHORT_GAP)  low = (int'(s0) <= 17) ? {2'b11, s0} : {2'b10, s0};
        else if (int'(s0) >= 4) low = {2'b01, s0};
        else                  low = {2'b00, late_offset(s1), s0[1:0]};
      end
      default: low = (g1 <= SHORT_GAP && g2 <= SHORT_GAP && int'(s0) <= 4)
                     ? {2'b11, s0} : {2'b10, s0};
    endcase
    return {lvl, low};
  endfunction
endpackage

// File: rtl/tpe_sync.sv
module tpe_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] q,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_ln
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], din[i]};
    end
    assign q[i]    = sh[1];
    assign fall[i] = sh[2] & ~sh[1];
  end
endmodule

// File: rtl/tpe_detect.sv
module tpe_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rz_mode,
  input  logic       mark_sel,
  input  logic [1:0] lv,
  input  logic [1:0] fl,
  input  logic       viol_block,
  output logic       ev,
  output logic       viol_ev,
  output logic       lvl
);
  logic mark_f, space_f, lv_m, lv_s, mark_hit, space_hit;
  logic trans, viol_cand, lvl_nxt;

  assign mark_f    = mark_sel ? fl[1] : fl[0];
  assign space_f   = mark_sel ? fl[0] : fl[1];
  assign lv_m      = mark_sel ? lv[1] : lv[0];
  assign lv_s      = mark_sel ? lv[0] : lv[1];
  assign mark_hit  = mark_f & lv_s;   // other line must be idle high
  assign space_hit = space_f & lv_m;

  always_comb begin
    trans     = 1'b0;
    viol_cand = 1'b0;
    lvl_nxt   = lvl;
    if (rz_mode) begin
      if (mark_hit || space_hit) begin
        if (mark_hit != lvl) begin
          trans   = 1'b1;
          lvl_nxt = mark_hit;
        end else begin
          viol_cand = 1'b1;
        end
      end
    end else if (lv[0] != lvl) begin
      trans   = 1'b1;
      lvl_nxt = lv[0];
    end
  end

  assign viol_ev = viol_cand & ~viol_block;
  assign ev      = trans | viol_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl <= 1'b0;
    else        lvl <= lvl_nxt;
  end
endmodule

// File: rtl/tpe_capture.sv
module tpe_capture
  import tpe_pkg::*;
#(
  parameter int CYC_PER_SLOT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev,
  input  logic       viol_ev,
  output logic       win_start,
  output logic       primed,
  output logic       viol_block,
  output logic [1:0] n_q,
  output slot_t      s0_q,
  output slot_t      s1_q,
  output slot_t      s2_q
);
  localparam int WIN  = SLOTS * CYC_PER_SLOT;
  localparam int CW   = $clog2(WIN);
  localparam int LAST = WIN - 1;

  logic [CW-1:0] cnt;
  logic          last, vseen;
  slot_t         slot_now;

  assign win_start  = (cnt == '0);
  assign last       = (cnt == CW'(LAST));
  assign slot_now   = slot_t'(cnt / CW'(CYC_PER_SLOT));
  assign viol_block = vseen & ~win_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      primed <= 1'b0;
    end else begin
      cnt    <= last ? '0 : cnt + 1'b1;
      primed <= primed | last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q   <= 2'd0;
      s0_q  <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      vseen <= 1'b0;
    end else if (win_start) begin
      n_q   <= ev ? 2'd1 : 2'd0;
      s0_q  <= slot_now;
      s1_q  <= '0;
      s2_q  <= '0;
      vseen <= viol_ev;
    end else begin
      vseen <= vseen | viol_ev;
      if (ev) begin
        case (n_q)
          2'd0:    s0_q <= slot_now;
          2'd1:    s1_q <= slot_now;
          2'd2:    s2_q <= slot_now;
          default: ;
        endcase
        if (n_q != 2'd3) n_q <= n_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/tpe_encoder.sv
module tpe_encoder
  import tpe_pkg::*;
#(
  parameter int CYC_PER_SLOT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rz_mode,
  input  logic       mark_sel,
  input  logic       line_a,
  input  logic       line_b,
  output logic [7:0] code_word,
  output logic       word_valid
);
  logic [1:0] sync_lv, sync_fl;
  logic       ev, viol_ev, lvl, win_start, primed, viol_block;
  logic [1:0] n_q;
  slot_t      s0_q, s1_q, s2_q;

  tpe_sync #(.N(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({line_b, line_a}), .q(sync_lv), .fall(sync_fl)
  );

  tpe_detect u_det (
    .clk(clk), .rst_n(rst_n), .rz_mode(rz_mode), .mark_sel(mark_sel),
    .lv(sync_lv), .fl(sync_fl), .viol_block(viol_block),
    .ev(ev), .viol_ev(viol_ev), .lvl(lvl)
  );

  tpe_capture #(.CYC_PER_SLOT(CYC_PER_SLOT)) u_cap (
    .clk(clk), .rst_n(rst_n), .ev(ev), .viol_ev(viol_ev),
    .win_start(win_start), .primed(primed), .viol_block(viol_block),
    .n_q(n_q), .s0_q(s0_q), .s1_q(s1_q), .s2_q(s2_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_word  <= 8'h7F;
      word_valid <= 1'b0;
    end else begin
      word_valid <= win_start & primed;
      if (win_start && primed) code_word <= tpe_pack(lvl, n_q, s0_q, s1_q, s2_q);
    end
  end
endmodule

// File: rtl/tpe_checker.sv
module tpe_checker #(
  parameter int PERIOD = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       word_valid,
  input logic [7:0] code_word,
  input logic       viol_ev,
  input logic       win_start,
  input logic       lvl
);
  localparam int GW = $clog2(PERIOD) + 1;
  logic [GW-1:0] gap;
  logic          seen;
  logic [1:0]    vcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
      vcnt <= 2'd0;
    end else begin
      if (word_valid) begin
        gap  <= '0;
        seen <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
      if (win_start)          vcnt <= {1'b0, viol_ev};
      else if (vcnt != 2'd3)  vcnt <= vcnt + {1'b0, viol_ev};
    end
  end

  AST_STROBE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && seen) |-> (gap == GW'(PERIOD - 1)));  // R2
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(code_word));  // R14
  AST_SHORT_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && code_word[6:5] == 2'b11) |-> (code_word[4:0] <= 5'd17 || code_word[4:0] == 5'd31));  // R5
  AST_LONG_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && code_word[6:5] == 2'b01) |-> (code_word[4:0] >= 5'd4));  // R6
  AST_VIOL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    viol_ev |=> $stable(lvl));  // R11
  AST_ONE_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt <= 2'd1);  // R12
endmodule

bind tpe_encoder tpe_checker #(.PERIOD(32 * CYC_PER_SLOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .code_word(code_word),
  .viol_ev(viol_ev), .win_start(win_start), .lvl(lvl)
);

// File: tb/sim_tpe_encoder.sv
`timescale 1ns/1ps
module sim_tpe_encoder;
  localparam int CPS = 8;
  localparam int WIN = 32 * CPS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rz_mode = 1'b0, mark_sel = 1'b0, line_a = 1'b0, line_b = 1'b0;
  logic [7:0] code_word;
  logic word_valid;

  int nchk = 0, nfail = 0;
  int nev;
  int es[4];
  int ek[4];          // RZ: 0 = pulse on line_a, 1 = pulse on line_b, 2 = both lines
  logic ml = 1'b0;    // model level
  logic [7:0] prev_exp;
  bit have_prev = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tpe_encoder #(.CYC_PER_SLOT(CPS)) u0 (
    .clk(clk), .rst_n(rst_n), .rz_mode(rz_mode), .mark_sel(mark_sel),
    .line_a(line_a), .line_b(line_b), .code_word(code_word), .word_valid(word_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_word(input logic l, input int n, input int a, input int b, input int c);
    int w;
    if (n == 0)      w = 127;
    else if (n == 1) w = 64 + a;
    else if (n == 2) begin
      if (b - a < 20) w = (a < 18) ? 96 + a : 64 + a;
      else if (a > 3) w = 32 + a;
      else            w = ((b >= 28 ? b - 28 : 0) * 4) + a;
    end else begin
      w = (b - a < 20 && c - b < 20 && a < 5) ? 96 + a : 64 + a;
    end
    return {l, 7'(w)};
  endfunction

  task automatic run_frame(input string req);
    int cntv = 0;
    int sl[3] = '{0, 0, 0};
    bit vused = 0;
    logic [7:0] exp;
    for (int i = 0; i < nev; i++) begin
      bit take = 0;
      if (!rz_mode) begin
        ml = ~ml; take = 1;
      end else if (ek[i] != 2) begin
        logic is_mark;
        is_mark = (ek[i] == 0) ? ~mark_sel : mark_sel;
        if (is_mark != ml) begin ml = is_mark; take = 1; end
        else if (!vused) begin vused = 1; take = 1; end
      end
      if (take) begin
        if (cntv < 3) sl[cntv] = es[i];
        cntv++;
      end
    end
    exp = exp_word(ml, (cntv > 3) ? 3 : cntv, sl[0], sl[1], sl[2]);
    for (int c = 1; c <= WIN; c++) begin
      for (int i = 0; i < nev; i++) begin
        if (c == CPS * es[i] + 1) begin
          if (!rz_mode) line_a = ~line_a;
          else begin
            if (ek[i] != 1) line_a = 1'b0;
            if (ek[i] != 0) line_b = 1'b0;
          end
        end
        if (rz_mode && c == CPS * es[i] + 5) begin line_a = 1'b1; line_b = 1'b1; end
      end
      if (c == 2 && have_prev) begin
        check(word_valid == 1'b0, "R2 strobe width", int'(word_valid), 0);
        check(code_word == prev_exp, "R14 word held", int'(code_word), int'(prev_exp));
      end
      @(negedge clk);
    end
    check(word_valid == 1'b1, "R2 strobe due", int'(word_valid), 1);
    check(code_word == exp, req, int'(code_word), int'(exp));
    check(code_word[7] == ml, "R10 level bit", int'(code_word[7]), int'(ml));
    prev_exp = exp;
    have_prev = 1;
  endtask

  task automatic set_ev(input int n, input int a, input int b, input int c, input int d);
    nev = n;
    es[0] = a; es[1] = b; es[2] = c; es[3] = d;
  endtask

  initial begin
    int wd = 0;
    ek = '{0, 0, 0, 0};
    repeat (4) @(negedge clk);
    check(code_word == 8'h7F && word_valid == 1'b0, "R1 reset state", int'(code_word), 8'h7F);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(code_word == 8'h7F && word_valid == 1'b0, "R1 before first strobe", int'(code_word), 8'h7F);
    while (!word_valid && wd < 2000) begin @(negedge clk); wd++; end
    check(word_valid == 1'b1, "R2 first strobe", int'(word_valid), 1);
    check(code_word == 8'h7F, "R3 idle window", int'(code_word), 8'h7F);
    prev_exp = 8'h7F; have_prev = 1;

    // NRZ sweeps
    set_ev(0, 0, 0, 0, 0); run_frame("R3 idle NRZ");
    for (int s = 0; s < 32; s++) begin set_ev(1, s, 0, 0, 0); run_frame("R4 single slot"); end
    for (int a = 0; a <= 18; a++) begin
      set_ev(2, a, a + 13, 0, 0);
      run_frame(a <= 17 ? "R5 short pair" : "R9 short pair late");
    end
    for (int a = 0; a <= 5; a++) begin
      set_ev(2, a, a + 26, 0, 0);
      run_frame(a >= 4 ? "R6 long pair" : "R7 long pair early");
    end
    for (int a = 0; a <= 5; a++) begin
      set_ev(3, a, a + 13, a + 26, 0);
      run_frame(a <= 4 ? "R8 short triple" : "R9 triple late");
    end
    set_ev(3, 2, 24, 28, 0); run_frame("R9 uneven triple");

    // RZ, line_a is MARK
    rz_mode = 1'b1; line_a = 1'b1; line_b = 1'b1; mark_sel = 1'b0;
    set_ev(0, 0, 0, 0, 0); run_frame("R3 idle RZ");
    for (int m = 0; m < 2; m++) begin
      mark_sel = m[0];
      ek = '{0, 0, 0, 0}; set_ev(1, 6, 0, 0, 0);   run_frame("R11 pulse line_a");
      ek = '{0, 0, 0, 0}; set_ev(1, 9, 0, 0, 0);   run_frame("R11 violation line_a");
      ek = '{1, 1, 0, 0}; set_ev(2, 3, 10, 0, 0);  run_frame("R11 pulse line_b then violation");
      ek = '{1, 1, 1, 0}; set_ev(3, 4, 12, 20, 0); run_frame("R12 repeated violations");
      ek = '{1, 1, 0, 1}; set_ev(4, 2, 8, 15, 22); run_frame("R12 violation limit with data");
      ek = '{2, 0, 0, 0}; set_ev(1, 8, 0, 0, 0);   run_frame("R13 both lines low");
      ek = '{2, 0, 0, 0}; set_ev(2, 5, 18, 0, 0);  run_frame("R13 both then line_a");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule